// File: doc/BRIEF.md
# Synchronous Serial Shift Unit

This block moves bytes over a clocked serial link with one transmit data line, one receive data line and one serial clock line. Each transfer is eight bits, least significant bit first. A single write loads a byte, which is shifted out while a byte is shifted in at the same time. There are no start, stop or parity bits. The transmit line changes on the rising edge of the serial clock. The receive line is captured on its falling edge. The serial clock runs at the bit rate, with no oversampling.

A single select input decides where the serial clock comes from. In the external setting the clock pin is an input: it passes through a two-flop synchronizer and its edges are found in the system clock domain. In the internal setting the unit drives the clock pin itself. The generated clock toggles once per bit-rate tick while a transfer is in progress and rests high otherwise. The transmit path has a holding register in front of the shifter, so software can queue the next byte while the current one is still shifting. A full flag marks a received byte until software reads it.

Top module: `sync_shift_unit`

## Requirements
- R1: While reset is asserted and just after it is released: `txd_o` is 1, `sclk_o` is 1, `tx_empty_o` is 1, `rx_full_o` is 0 and `busy_o` is 0.
- R2: `sclk_oe_o` is 1 when `clk_int_sel_i` is 1 (the clock is generated internally) and 0 when it is 0 (the clock comes from `sclk_i`).
- R3: In internal mode, `sclk_o` inverts on each `bit_tick_i` pulse while `busy_o` is 1. One byte therefore spans 16 ticks, giving 8 falling and 8 rising edges. The clock rests high whenever `busy_o` is 0.
- R4: Bit 0 of a loaded byte appears on `txd_o` as soon as the byte enters the shifter. `txd_o` moves to the next higher bit only on a rising serial clock edge, so the bits go out least significant first.
- R5: `rxd_i` is sampled on each falling serial clock edge and shifted in least significant bit first. On the 8th rising edge, the assembled byte appears on `rd_data_o` and `rx_full_o` is set.
- R6: A one-cycle `rd_en_i` pulse clears `rx_full_o` on the next clock, unless a new byte completes in the same cycle.
- R7: `wr_en_i` stores `wr_data_i` in the holding register and clears `tx_empty_o`. `tx_empty_o` sets again when the byte moves into the shifter. A byte that is waiting is loaded on the 8th rising edge of the current byte, so `busy_o` stays 1 between the two bytes.
- R8: In external mode, `sclk_i` edges are synchronized through two flip-flops. Edges that arrive while `busy_o` is 0 have no effect: no byte is received and `txd_o` stays 1.
- R9: If the holding register is empty after the 8th rising edge, `busy_o` falls and `txd_o` returns to 1.
- R10: `bit_tick_i` has no effect on `sclk_o` while the unit is idle or in external mode; `sclk_o` then stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_int_sel_i | input | 1 | 1: generate the serial clock internally; 0: take it from sclk_i |
| bit_tick_i | input | 1 | One-cycle pulse from the bit-rate source; each pulse is one half period of the generated clock |
| sclk_i | input | 1 | Serial clock from the pin (external mode) |
| sclk_o | output | 1 | Generated serial clock (internal mode) |
| sclk_oe_o | output | 1 | Output enable of the clock pin |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |
| wr_en_i | input | 1 | Write the transmit holding register |
| wr_data_i | input | 8 | Byte to transmit |
| tx_empty_o | output | 1 | Transmit holding register is empty |
| rd_en_i | input | 1 | Read strobe for the received byte |
| rd_data_o | output | 8 | Last received byte |
| rx_full_o | output | 1 | A received byte is waiting |
| busy_o | output | 1 | A transfer is in progress |

## Verification
The hardest case to reach is the hand-over between two bytes. The waiting byte must move into the shifter in the same cycle as the 8th rising edge. If it does not, the clock stops for one cycle and `busy_o` shows a gap. The bench writes a second byte while the first is still shifting. It counts how many times `busy_o` falls across the pair and how many rising clock edges occur. In external mode it drives bursts of clock pulses both while the unit is idle and across two queued bytes. A bench-side serial partner checks both data directions bit by bit.

// File: rtl/sync_shift_pkg.sv
package sync_shift_pkg;

  typedef enum logic {
    SRC_EXTERNAL = 1'b0,
    SRC_INTERNAL = 1'b1
  } clk_src_e;

  typedef struct packed {
    logic fall;
    logic rise;
  } sclk_evt_t;

endpackage

// File: rtl/sync_shift_clkgen.sv
module sync_shift_clkgen
  import sync_shift_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  clk_src_e  src_i,
  input  logic      bit_tick_i,
  input  logic      sclk_pin_i,
  input  logic      rxd_pin_i,
  input  logic      active_i,
  output logic      sclk_drv_o,
  output sclk_evt_t evt_o,
  output logic      rxd_sync_o
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_sync_q, sclk_sync_d;
  logic [SYNC_STAGES-1:0] rxd_sync_q, rxd_sync_d;
  logic ext_prev_q, ext_prev_d;
  logic int_clk_q, int_clk_d;
  logic ext_fall, ext_rise;

  // synchronizer chains
  assign sclk_sync_d[0] = sclk_pin_i;
  assign rxd_sync_d[0]  = rxd_pin_i;
  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_chain
    assign sclk_sync_d[s] = sclk_sync_q[s-1];
    assign rxd_sync_d[s]  = rxd_sync_q[s-1];
  end

  always_comb begin
    ext_prev_d = sclk_sync_q[MSB];
    ext_fall   = ext_prev_q & ~sclk_sync_q[MSB];
    ext_rise   = ~ext_prev_q & sclk_sync_q[MSB];

    // generated clock rests high outside a transfer
    int_clk_d = int_clk_q;
    if (!active_i || (src_i == SRC_EXTERNAL)) begin
      int_clk_d = 1'b1;
    end else if (bit_tick_i) begin
      int_clk_d = ~int_clk_q;
    end

    if (src_i == SRC_INTERNAL) begin
      evt_o.fall = active_i & bit_tick_i & int_clk_q;
      evt_o.rise = active_i & bit_tick_i & ~int_clk_q;
    end else begin
      evt_o.fall = active_i & ext_fall;
      evt_o.rise = active_i & ext_rise;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_sync_q <= '1;
      rxd_sync_q  <= '1;
      ext_prev_q  <= 1'b1;
      int_clk_q   <= 1'b1;
    end else begin
      sclk_sync_q <= sclk_sync_d;
      rxd_sync_q  <= rxd_sync_d;
      ext_prev_q  <= ext_prev_d;
      int_clk_q   <= int_clk_d;
    end
  end

  assign sclk_drv_o = int_clk_q;
  assign rxd_sync_o = rxd_sync_q[MSB];

endmodule

// File: rtl/sync_shift_tx.sv
module sync_shift_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rise_i,
  input  logic              done_i,
  output logic              load_o,
  output logic              busy_o,
  output logic              txd_o,
  output logic              empty_o
);

  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_en;
  logic              hold_full_q, hold_full_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic              shf_en;
  logic              busy_q, busy_d;

  assign load_o = hold_full_q & (~busy_q | done_i);

  always_comb begin
    hold_en     = wr_en_i;
    hold_d      = wr_data_i;
    hold_full_d = wr_en_i | (hold_full_q & ~load_o);

    shf_en = 1'b0;
    shf_d  = shf_q;
    busy_d = busy_q;
    if (load_o) begin
      shf_en = 1'b1;
      shf_d  = hold_q;
      busy_d = 1'b1;
    end else if (done_i) begin
      shf_en = 1'b1;
      shf_d  = '1;
      busy_d = 1'b0;
    end else if (rise_i && busy_q) begin
      shf_en = 1'b1;
      shf_d  = {1'b1, shf_q[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      shf_q       <= '1;
      busy_q      <= 1'b0;
    end else begin
      if (hold_en) hold_q <= hold_d;
      if (shf_en)  shf_q  <= shf_d;
      hold_full_q <= hold_full_d;
      busy_q      <= busy_d;
    end
  end

  assign busy_o  = busy_q;
  assign txd_o   = shf_q[0];
  assign empty_o = ~hold_full_q;

endmodule

// File: rtl/sync_shift_rx.sv
module sync_shift_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              rxd_i,
  input  logic              done_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              full_o
);

  logic [DATA_W-1:0] shf_q, shf_d;
  logic [DATA_W-1:0] buf_q;
  logic              full_q, full_d;

  always_comb begin
    shf_d  = {rxd_i, shf_q[DATA_W-1:1]};
    full_d = done_i | (full_q & ~rd_en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shf_q  <= '0;
      buf_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (fall_i) shf_q <= shf_d;
      if (done_i) buf_q <= shf_q;
      full_q <= full_d;
    end
  end

  assign rd_data_o = buf_q;
  assign full_o    = full_q;

endmodule

// File: rtl/sync_shift_unit.sv
module sync_shift_unit
  import sync_shift_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_int_sel_i,
  input  logic              bit_tick_i,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic              txd_o,
  input  logic              rxd_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              tx_empty_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rx_full_o,
  output logic              busy_o
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  sclk_evt_t        evt;
  logic             rxd_sync;
  logic             load;
  logic             busy;
  logic             done;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  sync_shift_clkgen #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (clk_src_e'(clk_int_sel_i)),
    .bit_tick_i (bit_tick_i),
    .sclk_pin_i (sclk_i),
    .rxd_pin_i  (rxd_i),
    .active_i   (busy),
    .sclk_drv_o (sclk_o),
    .evt_o      (evt),
    .rxd_sync_o (rxd_sync)
  );

  // bit counter: cleared on load and at the end of a byte
  assign done = evt.rise & (cnt_q == LAST_BIT);

  always_comb begin
    cnt_d = cnt_q;
    if (load || done) begin
      cnt_d = '0;
    end else if (evt.rise) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  sync_shift_tx #(
    .DATA_W(DATA_W)
  ) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rise_i    (evt.rise),
    .done_i    (done),
    .load_o    (load),
    .busy_o    (busy),
    .txd_o     (txd_o),
    .empty_o   (tx_empty_o)
  );

  sync_shift_rx #(
    .DATA_W(DATA_W)
  ) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (evt.fall),
    .rxd_i     (rxd_sync),
    .done_i    (done),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .full_o    (rx_full_o)
  );

  assign sclk_oe_o = clk_int_sel_i;
  assign busy_o    = busy;

endmodule

// File: rtl/sync_shift_unit_chk.sv
module sync_shift_unit_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clk_int_sel_i,
  input logic sclk_o,
  input logic txd_o,
  input logic tx_empty_o,
  input logic rd_en_i,
  input logic rx_full_o,
  input logic busy_o
);

  assert_idle_clk_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sclk_o);

  assert_txd_on_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_int_sel_i && busy_o && $past(busy_o) && !$stable(txd_o)) |-> $rose(sclk_o));

  assert_full_from_transfer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_o) |-> $past(busy_o));

  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !busy_o) |=> !rx_full_o);

  assert_empty_on_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty_o) |-> busy_o);

  assert_txd_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);

  assert_ext_clk_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_int_sel_i |-> sclk_o);

endmodule

bind sync_shift_unit sync_shift_unit_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .clk_int_sel_i (clk_int_sel_i),
  .sclk_o        (sclk_o),
  .txd_o         (txd_o),
  .tx_empty_o    (tx_empty_o),
  .rd_en_i       (rd_en_i),
  .rx_full_o     (rx_full_o),
  .busy_o        (busy_o)
);

// File: tb/sim_sync_shift_unit.sv
`timescale 1ns/1ps
module sim_sync_shift_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b1;
  logic       tick = 1'b0;
  logic       tick_en = 1'b0;
  logic       ext_sclk = 1'b1;
  logic       rxd = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic       sclk_o, sclk_oe, txd, tx_empty, rx_full, busy;
  logic [7:0] rd_data;

  int errs = 0;
  int checks = 0;

  logic [7:0] tx_exp[$];
  logic [7:0] rx_send[$];
  logic [7:0] rx_exp[$];

  // serial partner state
  logic       partner_en = 1'b1;
  logic       prev_line = 1'b1;
  logic       line;
  logic [7:0] cap = 8'h00;
  int         pbit = 0;
  int         rise_cnt = 0;
  int         busy_falls = 0;
  logic       busy_prev = 1'b0;
  int         tick_cnt = 0;

  always #4 clk = ~clk;

  sync_shift_unit u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .clk_int_sel_i (sel),
    .bit_tick_i    (tick),
    .sclk_i        (ext_sclk),
    .sclk_o        (sclk_o),
    .sclk_oe_o     (sclk_oe),
    .txd_o         (txd),
    .rxd_i         (rxd),
    .wr_en_i       (wr_en),
    .wr_data_i     (wr_data),
    .tx_empty_o    (tx_empty),
    .rd_en_i       (rd_en),
    .rd_data_o     (rd_data),
    .rx_full_o     (rx_full),
    .busy_o        (busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit-rate tick: one pulse every 6 clocks
  always @(negedge clk) begin
    tick_cnt = (tick_cnt == 5) ? 0 : tick_cnt + 1;
    tick = tick_en && (tick_cnt == 0);
  end

  // serial partner: samples txd on falling, presents rxd, scores on 8th rising
  always @(negedge clk) begin
    logic [7:0] e;
    line = sel ? sclk_o : ext_sclk;
    if (partner_en && rst_n) begin
      if (prev_line && !line) cap = {txd, cap[7:1]};
      if (!prev_line && line) begin
        rise_cnt++;
        pbit++;
        if (pbit == 8) begin
          pbit = 0;
          if (tx_exp.size() > 0) begin
            e = tx_exp.pop_front();
            chk(cap == e, "R4 tx byte", cap, e);
          end else begin
            chk(1'b0, "R4 unexpected tx byte", cap, 0);
          end
          if (rx_send.size() > 0) void'(rx_send.pop_front());
        end
      end
      rxd = (rx_send.size() > 0) ? rx_send[0][pbit] : 1'b1;
    end
    prev_line = line;
  end

  // receive monitor: pops expected bytes and reads them out
  always @(negedge clk) begin
    logic [7:0] e;
    if (rd_en) begin
      rd_en = 1'b0;
      chk(!rx_full, "R6 full cleared by read", rx_full, 0);
    end else if (rst_n && rx_full) begin
      if (rx_exp.size() > 0) begin
        e = rx_exp.pop_front();
        chk(rd_data == e, "R5 rx byte", rd_data, e);
      end else begin
        chk(1'b0, "R5 unexpected rx byte", rd_data, 0);
      end
      rd_en = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (busy_prev && !busy) busy_falls++;
    busy_prev = busy;
  end

  task automatic send(input logic [7:0] t, input logic [7:0] r);
    tx_exp.push_back(t);
    rx_send.push_back(r);
    rx_exp.push_back(r);
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
    wr_en = 1'b1;
    wr_data = t;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ext_pulses(input int n);
    repeat (n) begin
      @(posedge clk); #1 ext_sclk = 1'b0;
      repeat (8) @(posedge clk);
      #1 ext_sclk = 1'b1;
      repeat (8) @(posedge clk);
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((busy || rx_full || rd_en || tx_exp.size() > 0 || rx_exp.size() > 0) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 3000, "R9 unit returns to idle", n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd == 1'b1,     "R1 txd in reset", txd, 1);
    chk(sclk_o == 1'b1,  "R1 sclk in reset", sclk_o, 1);
    chk(tx_empty == 1'b1,"R1 tx_empty in reset", tx_empty, 1);
    chk(rx_full == 1'b0, "R1 rx_full in reset", rx_full, 0);
    chk(busy == 1'b0,    "R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1 && busy == 1'b0, "R1 idle after release", {txd, busy}, 2);
    chk(sclk_oe == 1'b1, "R2 oe in internal mode", sclk_oe, 1);

    // idle ticks must not move the clock
    tick_en = 1'b1;
    repeat (40) @(negedge clk);
    chk(rise_cnt == 0 && sclk_o == 1'b1, "R10 idle ticks ignored", rise_cnt, 0);

    // back-to-back pair in internal mode
    busy_falls = 0;
    rise_cnt = 0;
    send(8'hA5, 8'h3C);
    send(8'h0F, 8'hF0);
    chk(tx_empty == 1'b0, "R7 second byte held", tx_empty, 0);
    chk(busy == 1'b1, "R7 first byte shifting", busy, 1);
    wait_idle();
    chk(busy_falls == 1, "R7 no gap between bytes", busy_falls, 1);
    chk(rise_cnt == 16, "R3 rising edges for two bytes", rise_cnt, 16);
    chk(txd == 1'b1, "R9 txd high after last byte", txd, 1);
    chk(sclk_o == 1'b1, "R3 clock rests high", sclk_o, 1);

    send(8'h80, 8'h01); wait_idle();
    send(8'hFF, 8'h00); wait_idle();
    send(8'h00, 8'hFF); wait_idle();

    // external mode
    sel = 1'b0;
    @(negedge clk);
    chk(sclk_oe == 1'b0, "R2 oe in external mode", sclk_oe, 0);
    partner_en = 1'b0;
    ext_pulses(3);
    repeat (6) @(negedge clk);
    chk(busy == 1'b0,    "R8 idle edges ignored busy", busy, 0);
    chk(rx_full == 1'b0, "R8 idle edges ignored rx", rx_full, 0);
    chk(txd == 1'b1,     "R8 idle edges ignored txd", txd, 1);
    pbit = 0;
    prev_line = 1'b1;
    partner_en = 1'b1;

    send(8'h5A, 8'hC3);
    ext_pulses(4);
    chk(sclk_o == 1'b1, "R10 ticks ignored in external mode", sclk_o, 1);
    chk(busy == 1'b1, "R8 shifting on external clock", busy, 1);
    ext_pulses(4);
    wait_idle();

    send(8'h01, 8'h80);
    send(8'h7E, 8'h81);
    ext_pulses(16);
    wait_idle();

    chk(tx_exp.size() == 0, "R4 all tx bytes seen", tx_exp.size(), 0);
    chk(rx_exp.size() == 0, "R5 all rx bytes seen", rx_exp.size(), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule